// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss entirely in hardware. It takes a 32-bit virtual address and the current page table pointer. It reads the first-level entry from memory and decides from the type bit whether the entry maps a 2 MB page or points at a second-level table. For a table pointer it fetches the two-word second-level entry. It returns a refill record that holds the page frame number, the page size and the final flag bits, or it returns a one-hot fault code.

When the local-access flag of the selected entry is clear, the walker sets it before it completes. On a write miss it also sets the dirty flag when that flag is clear. The update is a load-linked read followed by a store-conditional write. A store-conditional that is refused restarts the update from the load-linked read.

Memory is reached through one request/response port. The walker holds the request until a response arrives, and the response carries a bus-error flag and a store-conditional failure flag. A miss is accepted only while the walker is idle.

Top module: `ptw_walker`

## Requirements
- R1: The first memory request of a walk is a read (op code 0) at the 40-bit address {ptpr_i[26:0], vaddr[31:21], 2'b00}.
- R2: Entry flag bits are V=31, T=30, L=29, R=28, C=27, W=26, X=25, U=24, G=23, D=22. A first-level word with V=1 and T=0 ends the walk with no second-level read, with rec_huge_o=1 and rec_ppn_o equal to word[18:0] zero-extended.
- R3: A first-level word with V=1 and T=1 takes table base word[27:0]. The walker then reads the flags word at {base, vaddr[20:12], 3'b000} and the frame word at {base, vaddr[20:12], 3'b100}, and ends with rec_huge_o=0 and rec_ppn_o equal to the frame word's [27:0].
- R4: V=0 in the first-level word ends the walk with code 0x001. V=0 in the second-level flags word ends it with code 0x002, and no frame word is read.
- R5: A bus error on any access to a first-level entry ends the walk with code 0x040. A bus error on any access to a second-level entry ends it with code 0x080. This covers the load-linked and store-conditional accesses.
- R6: If L is clear in the entry's flags word, the walker issues a load-linked (op 1) and then a store-conditional (op 2) at that word's address. The stored value is the load-linked data with L set, and rec_flags_o equals bits [31:22] of the stored value.
- R7: On a write miss with D clear, D is set in the same store. A read miss never sets D. If no bit needs setting, no load-linked or store-conditional is issued.
- R8: A store-conditional answered with mem_sc_fail_i=1 is followed by a new load-linked read of the same address. The walk completes after the first successful store-conditional.
- R9: busy_o rises in the cycle after miss_valid_i is seen while idle and stays high until the completion cycle. miss_valid_i while busy is ignored.
- R10: mem_req_o, mem_addr_o and mem_op_o stay unchanged until mem_rvalid_i answers the request.
- R11: done_o (success, err_code_o=0) or err_o (failure) is high for exactly one cycle per walk, and busy_o is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Translation miss request |
| miss_vaddr_i | input | 32 | Virtual address that missed |
| miss_write_i | input | 1 | Miss comes from a write access |
| ptpr_i | input | 27 | Upper bits of the first-level table base |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory request valid |
| mem_op_o | output | 2 | 0 read, 1 load-linked, 2 store-conditional |
| mem_addr_o | output | 40 | Physical byte address |
| mem_wdata_o | output | 32 | Store-conditional data |
| mem_rvalid_i | input | 1 | Response for the pending request |
| mem_rdata_i | input | 32 | Read or load-linked data |
| mem_err_i | input | 1 | Bus error on the response |
| mem_sc_fail_i | input | 1 | Store-conditional refused |
| done_o | output | 1 | Walk completed with a refill record |
| err_o | output | 1 | Walk ended with a fault |
| err_code_o | output | 9 | One-hot fault code |
| rec_vaddr_o | output | 32 | Virtual address of the walk |
| rec_huge_o | output | 1 | 2 MB mapping |
| rec_ppn_o | output | 28 | Physical page number |
| rec_flags_o | output | 10 | Final flag bits V..D |

## Verification
On every cycle the assertions check several port-level rules. A request is held stable until it is answered. A walk starts only from an accepted miss. The completion pulse lasts one cycle and is followed by idle. A fault code is one-hot. Every store-conditional carries L set, and a refused store-conditional is followed by a load-linked read at the same address. Correct decoding, the computed table addresses, the choice and count of memory accesses, the selection of fault codes and the final memory contents after an update can only be shown by the bench. It runs the scenarios against a memory model and compares the results with a walk model written independently of the design.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 40;
  localparam int WORD_W  = 32;
  localparam int PG_OFS  = 12;
  localparam int VPN_W   = VA_W - PG_OFS;
  localparam int IDX1_W  = 11;
  localparam int IDX2_W  = VPN_W - IDX1_W;
  localparam int PTPR_W  = PA_W - IDX1_W - 2;
  localparam int PTBA_W  = PA_W - PG_OFS;
  localparam int PPN_W   = PA_W - PG_OFS;
  localparam int PPN1_W  = PA_W - 21;
  localparam int CODE_W  = 9;
  localparam int FLAG_W  = 10;

  localparam int B_V = 31;
  localparam int B_T = 30;
  localparam int B_L = 29;
  localparam int B_D = 22;

  localparam logic [CODE_W-1:0] C_L1_INV = 9'h001;
  localparam logic [CODE_W-1:0] C_L2_INV = 9'h002;
  localparam logic [CODE_W-1:0] C_L1_BUS = 9'h040;
  localparam logic [CODE_W-1:0] C_L2_BUS = 9'h080;

  typedef enum logic [1:0] {OP_READ = 2'd0, OP_LL = 2'd1, OP_SC = 2'd2} mem_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD1, S_RD2F, S_RD2P, S_LL, S_SC, S_RESP
  } walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int P_W  = PTPR_W,
  parameter int B_W  = PTBA_W,
  parameter int V_W  = VPN_W,
  parameter int I1_W = IDX1_W,
  parameter int I2_W = IDX2_W
) (
  input  logic [P_W-1:0]        ptpr_i,
  input  logic [B_W-1:0]        ptba_i,
  input  logic [V_W-1:0]        vpn_i,
  output logic [P_W+I1_W+1:0]   l1_addr_o,
  output logic [B_W+I2_W+2:0]   l2_flag_addr_o,
  output logic [B_W+I2_W+2:0]   l2_ppn_addr_o
);
  // first-level entries are one word, second-level entries two words
  assign l1_addr_o      = {ptpr_i, vpn_i[V_W-1 -: I1_W], 2'b00};
  assign l2_flag_addr_o = {ptba_i, vpn_i[I2_W-1:0], 3'b000};
  assign l2_ppn_addr_o  = {ptba_i, vpn_i[I2_W-1:0], 3'b100};
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
  import ptw_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              write_i,
  output logic              valid_o,
  output logic              table_o,
  output logic [PPN1_W-1:0] ppn1_o,
  output logic [PTBA_W-1:0] ptba_o,
  output logic [PPN_W-1:0]  ppn2_o,
  output logic              need_upd_o,
  output logic [WORD_W-1:0] upd_word_o
);
  logic [WORD_W-1:0] set_mask;

  assign valid_o = word_i[B_V];
  assign table_o = word_i[B_T];
  assign ppn1_o  = word_i[PPN1_W-1:0];
  assign ptba_o  = word_i[PTBA_W-1:0];
  assign ppn2_o  = word_i[PPN_W-1:0];

  always_comb begin
    set_mask = '0;
    set_mask[B_L] = ~word_i[B_L];
    set_mask[B_D] = write_i & ~word_i[B_D];
  end

  assign need_upd_o = |set_mask;
  assign upd_word_o = word_i | set_mask;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [VA_W-1:0]   miss_vaddr_i,
  input  logic              miss_write_i,
  input  logic [PTPR_W-1:0] ptpr_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [1:0]        mem_op_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_err_i,
  input  logic              mem_sc_fail_i,
  output logic              done_o,
  output logic              err_o,
  output logic [CODE_W-1:0] err_code_o,
  output logic [VA_W-1:0]   rec_vaddr_o,
  output logic              rec_huge_o,
  output logic [PPN_W-1:0]  rec_ppn_o,
  output logic [FLAG_W-1:0] rec_flags_o
);
  walk_st_e          state_q;
  logic [VA_W-1:0]   va_q;
  logic              wr_q;
  logic [WORD_W-1:0] ent_q;
  logic [PTBA_W-1:0] ptba_q;
  logic [PPN_W-1:0]  ppn_q;
  logic              huge_q, lvl2_q, need_q;
  logic [CODE_W-1:0] code_q;

  logic [PA_W-1:0]   l1_addr, l2f_addr, l2p_addr, ent_addr;
  logic              d_valid, d_table, d_need;
  logic [PPN1_W-1:0] d_ppn1;
  logic [PTBA_W-1:0] d_ptba;
  logic [PPN_W-1:0]  d_ppn2;
  logic [WORD_W-1:0] d_upd;
  logic [CODE_W-1:0] bus_code;

  ptw_addr_gen i_addr_gen (
    .ptpr_i         (ptpr_i),
    .ptba_i         (ptba_q),
    .vpn_i          (va_q[VA_W-1:PG_OFS]),
    .l1_addr_o      (l1_addr),
    .l2_flag_addr_o (l2f_addr),
    .l2_ppn_addr_o  (l2p_addr)
  );

  ptw_entry_dec i_entry_dec (
    .word_i     (mem_rdata_i),
    .write_i    (wr_q),
    .valid_o    (d_valid),
    .table_o    (d_table),
    .ppn1_o     (d_ppn1),
    .ptba_o     (d_ptba),
    .ppn2_o     (d_ppn2),
    .need_upd_o (d_need),
    .upd_word_o (d_upd)
  );

  assign ent_addr = lvl2_q ? l2f_addr : l1_addr;
  assign bus_code = lvl2_q ? C_L2_BUS : C_L1_BUS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      ent_q   <= '0;
      ptba_q  <= '0;
      ppn_q   <= '0;
      huge_q  <= 1'b0;
      lvl2_q  <= 1'b0;
      need_q  <= 1'b0;
      code_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (miss_valid_i) begin
          va_q    <= miss_vaddr_i;
          wr_q    <= miss_write_i;
          code_q  <= '0;
          huge_q  <= 1'b0;
          lvl2_q  <= 1'b0;
          state_q <= S_RD1;
        end
        S_RD1: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            code_q  <= C_L1_BUS;
            state_q <= S_RESP;
          end else if (!d_valid) begin
            code_q  <= C_L1_INV;
            state_q <= S_RESP;
          end else if (d_table) begin
            ptba_q  <= d_ptba;
            lvl2_q  <= 1'b1;
            state_q <= S_RD2F;
          end else begin
            ent_q   <= mem_rdata_i;
            ppn_q   <= PPN_W'(d_ppn1);
            huge_q  <= 1'b1;
            state_q <= d_need ? S_LL : S_RESP;
          end
        end
        S_RD2F: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            code_q  <= C_L2_BUS;
            state_q <= S_RESP;
          end else if (!d_valid) begin
            code_q  <= C_L2_INV;
            state_q <= S_RESP;
          end else begin
            ent_q   <= mem_rdata_i;
            need_q  <= d_need;
            state_q <= S_RD2P;
          end
        end
        S_RD2P: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            code_q  <= C_L2_BUS;
            state_q <= S_RESP;
          end else begin
            ppn_q   <= d_ppn2;
            state_q <= need_q ? S_LL : S_RESP;
          end
        end
        S_LL: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            code_q  <= bus_code;
            state_q <= S_RESP;
          end else begin
            // fresh copy of the entry; merge set bits into it
            ent_q <= d_upd;
            if (!lvl2_q) ppn_q <= PPN_W'(d_ppn1);
            state_q <= d_need ? S_SC : S_RESP;
          end
        end
        S_SC: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            code_q  <= bus_code;
            state_q <= S_RESP;
          end else if (mem_sc_fail_i) begin
            state_q <= S_LL;
          end else begin
            state_q <= S_RESP;
          end
        end
        S_RESP:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_op_o   = OP_READ;
    mem_addr_o = l1_addr;
    unique case (state_q)
      S_RD1:  mem_req_o = 1'b1;
      S_RD2F: begin mem_req_o = 1'b1; mem_addr_o = l2f_addr; end
      S_RD2P: begin mem_req_o = 1'b1; mem_addr_o = l2p_addr; end
      S_LL:   begin mem_req_o = 1'b1; mem_addr_o = ent_addr; mem_op_o = OP_LL; end
      S_SC:   begin mem_req_o = 1'b1; mem_addr_o = ent_addr; mem_op_o = OP_SC; end
      default: ;
    endcase
  end

  assign mem_wdata_o = ent_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_RESP) && (code_q == '0);
  assign err_o       = (state_q == S_RESP) && (code_q != '0);
  assign err_code_o  = code_q;
  assign rec_vaddr_o = va_q;
  assign rec_huge_o  = huge_q;
  assign rec_ppn_o   = ppn_q;
  assign rec_flags_o = ent_q[WORD_W-1 -: FLAG_W];

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_op_o));

  // R9
  walk_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(miss_valid_i));

  // R11
  resp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |=> !done_o && !err_o && !busy_o);

  // R4
  code_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $onehot0(err_code_o) && (err_code_o != '0));

  // R6
  sc_sets_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_op_o == OP_SC) |-> mem_wdata_o[B_L]);

  // R8
  sc_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_op_o == OP_SC && mem_rvalid_i && mem_sc_fail_i && !mem_err_i)
    |=> mem_req_o && mem_op_o == OP_LL && $stable(mem_addr_o));
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        miss_valid_i = 1'b0;
  logic [31:0] miss_vaddr_i = '0;
  logic        miss_write_i = 1'b0;
  logic [26:0] ptpr_i = '0;
  logic        busy_o, mem_req_o;
  logic [1:0]  mem_op_o;
  logic [39:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_err_i = 1'b0;
  logic        mem_sc_fail_i = 1'b0;
  logic        done_o, err_o, rec_huge_o;
  logic [8:0]  err_code_o;
  logic [31:0] rec_vaddr_o;
  logic [27:0] rec_ppn_o;
  logic [9:0]  rec_flags_o;

  ptw_walker i_ptw_walker (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0] mem [logic [39:0]];
  logic [39:0] err_addr = '1;
  logic [2:0]  err_ops = '0;
  int sc_fail_left = 0;
  int n_rd = 0, n_ll = 0, n_sc = 0;
  bit first_seen = 0;
  logic [39:0] first_addr = '0;
  logic [1:0]  first_op = '0;

  function automatic logic [31:0] rd(input logic [39:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // memory responder
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk_i);
      mem_rvalid_i = 0; mem_err_i = 0; mem_sc_fail_i = 0; mem_rdata_i = '0;
      if (rst_ni && mem_req_o) begin
        if (!first_seen) begin
          first_seen = 1; first_addr = mem_addr_o; first_op = mem_op_o;
        end
        if (wait_cnt > 0) wait_cnt--;
        else begin
          mem_rvalid_i = 1;
          case (mem_op_o)
            2'd0: n_rd++;
            2'd1: n_ll++;
            default: n_sc++;
          endcase
          if (mem_addr_o == err_addr && err_ops[mem_op_o]) mem_err_i = 1;
          else if (mem_op_o == 2'd2) begin
            if (sc_fail_left > 0) begin mem_sc_fail_i = 1; sc_fail_left--; end
            else mem[mem_addr_o] = mem_wdata_o;
          end else mem_rdata_i = rd(mem_addr_o);
          wait_cnt = $urandom % 3;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  // expected results
  logic [8:0]  e_code;
  logic        e_huge;
  logic [27:0] e_ppn;
  logic [31:0] e_final;
  logic [39:0] e_ent;
  int e_rd, e_ll, e_sc;

  task automatic model(input logic [31:0] va, input bit wr, input int nfail);
    logic [39:0] a1, a2f, a2p;
    logic [31:0] w, f, mask;
    bit lvl2, stop;
    e_code = 0; e_huge = 0; e_ppn = 0; e_final = 0; e_ll = 0; e_sc = 0; e_rd = 1;
    lvl2 = 0; stop = 0; f = 0;
    a1 = {ptpr_i, va[31:21], 2'b00};
    e_ent = a1;
    w = rd(a1);
    if (a1 == err_addr && err_ops[0]) begin e_code = 9'h040; stop = 1; end
    else if (!w[31]) begin e_code = 9'h001; stop = 1; end
    else if (!w[30]) begin f = w; e_huge = 1; e_ppn = {9'b0, w[18:0]}; end
    else begin
      lvl2 = 1;
      a2f = {w[27:0], va[20:12], 3'b000};
      a2p = {w[27:0], va[20:12], 3'b100};
      e_ent = a2f; e_rd = 2;
      f = rd(a2f);
      if (a2f == err_addr && err_ops[0]) begin e_code = 9'h080; stop = 1; end
      else if (!f[31]) begin e_code = 9'h002; stop = 1; end
      else begin
        e_rd = 3;
        if (a2p == err_addr && err_ops[0]) begin e_code = 9'h080; stop = 1; end
        else e_ppn = rd(a2p) & 32'h0FFF_FFFF;
      end
    end
    if (!stop) begin
      mask = 0;
      if (!f[29]) mask[29] = 1;
      if (wr && !f[22]) mask[22] = 1;
      e_final = f | mask;
      if (mask != 0) begin
        if (e_ent == err_addr && err_ops[1]) begin
          e_ll = 1; e_code = lvl2 ? 9'h080 : 9'h040;
        end else if (e_ent == err_addr && err_ops[2]) begin
          e_ll = 1; e_sc = 1; e_code = lvl2 ? 9'h080 : 9'h040;
        end else begin
          e_ll = nfail + 1; e_sc = nfail + 1;
        end
      end
    end
  endtask

  task automatic run_walk(input logic [31:0] va, input bit wr, input int nfail, input bit poke);
    int t;
    bit upd_ok;
    model(va, wr, nfail);
    n_rd = 0; n_ll = 0; n_sc = 0; first_seen = 0; sc_fail_left = nfail;
    @(negedge clk_i);
    miss_valid_i = 1; miss_vaddr_i = va; miss_write_i = wr;
    @(negedge clk_i);
    miss_valid_i = 0;
    chk(busy_o, "R9 busy after accept", 64'(busy_o), 1);
    if (poke) begin
      miss_valid_i = 1; miss_vaddr_i = ~va; miss_write_i = ~wr;
      @(negedge clk_i);
      miss_valid_i = 0;
    end
    t = 0;
    while (!(done_o || err_o) && t < 300) begin @(negedge clk_i); t++; end
    chk(first_addr == {ptpr_i, va[31:21], 2'b00} && first_op == 2'd0, "R1 first request",
        64'(first_addr), 64'({ptpr_i, va[31:21], 2'b00}));
    chk(err_code_o == e_code && done_o == (e_code == 0) && err_o == (e_code != 0),
        "R4 R5 completion code", 64'(err_code_o), 64'(e_code));
    chk(n_rd == e_rd, "R2 R3 read count", 64'(n_rd), 64'(e_rd));
    chk(n_ll == e_ll && n_sc == e_sc, "R6 R7 R8 atomic access count",
        64'({n_ll[15:0], n_sc[15:0]}), 64'({e_ll[15:0], e_sc[15:0]}));
    if (e_code == 0) begin
      chk(rec_huge_o == e_huge && rec_ppn_o == e_ppn, "R2 R3 refill page",
          64'({rec_huge_o, rec_ppn_o}), 64'({e_huge, e_ppn}));
      chk(rec_flags_o == e_final[31:22] && rec_vaddr_o == va, "R6 R7 refill flags",
          64'(rec_flags_o), 64'(e_final[31:22]));
      upd_ok = rd(e_ent) == e_final;
      chk(upd_ok, "R6 R7 entry in memory", 64'(rd(e_ent)), 64'(e_final));
    end
    @(negedge clk_i);
    chk(!busy_o && !done_o && !err_o, "R11 single pulse then idle",
        64'({busy_o, done_o, err_o}), 0);
    if (poke) begin
      @(negedge clk_i);
      chk(!busy_o && !mem_req_o, "R9 miss while busy ignored", 64'({busy_o, mem_req_o}), 0);
    end
  endtask

  // table builders
  logic [39:0] g_a1, g_a2f;
  task automatic build(input logic [31:0] va, input int kind, input logic [7:0] fl,
                       input logic [27:0] ppn);
    logic [27:0] ptba;
    mem.delete();
    g_a1 = {ptpr_i, va[31:21], 2'b00};
    ptba = $urandom;
    ptba[27] = ~ptpr_i[26];
    g_a2f = {ptba, va[20:12], 3'b000};
    case (kind)
      0: mem[g_a1] = {1'b0, 31'($urandom)};
      1: mem[g_a1] = {2'b10, fl, 3'b000, ppn[18:0]};
      2: begin
        mem[g_a1] = {2'b11, 2'b00, ptba};
        mem[g_a2f] = {2'b10, fl, 22'h0};
        mem[g_a2f | 40'h4] = {4'h0, ppn};
      end
      default: begin
        mem[g_a1] = {2'b11, 2'b00, ptba};
        mem[g_a2f] = {1'b0, 1'b0, fl, 22'h0};
      end
    endcase
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !mem_req_o && !done_o && !err_o, "R11 reset state",
        64'({busy_o, mem_req_o, done_o, err_o}), 0);
    rst_ni = 1;
    ptpr_i = 27'h5A5_1C3;

    // R2 huge page, L already set: no update
    build(32'h8A5F_3123, 1, 8'b1000_0000, 28'h7_1234);
    run_walk(32'h8A5F_3123, 0, 0, 0);
    // R6 huge page, L clear
    build(32'h1234_5678, 1, 8'b0011_0000, 28'h1_ABCD);
    run_walk(32'h1234_5678, 0, 0, 0);
    // R3 R7 second level, write with D clear
    build(32'hC0DE_F000, 2, 8'b1010_1110, 28'hABC_DEF1);
    run_walk(32'hC0DE_F000, 1, 0, 0);
    // R7 write, L and D already set: no update
    build(32'h4444_4444, 2, 8'b1000_0001, 28'h0F0_0F0F);
    run_walk(32'h4444_4444, 1, 0, 0);
    // R7 read miss leaves D clear
    build(32'h0000_1000, 2, 8'b0000_0000, 28'h000_0001);
    run_walk(32'h0000_1000, 0, 0, 0);
    // R8 two refused store-conditionals
    build(32'h7FFF_FFFF, 2, 8'b0000_0000, 28'hFFF_FFFF);
    run_walk(32'h7FFF_FFFF, 1, 2, 0);
    // R4 invalid first and second level
    build(32'h2000_0000, 0, 8'h0, 28'h0);
    run_walk(32'h2000_0000, 0, 0, 0);
    build(32'h3000_5000, 3, 8'hFF, 28'h0);
    run_walk(32'h3000_5000, 0, 0, 0);
    // R5 bus errors on each access kind
    build(32'h5555_5000, 2, 8'h00, 28'h123);
    err_addr = g_a1; err_ops = 3'b001;
    run_walk(32'h5555_5000, 0, 0, 0);
    build(32'h5555_5000, 2, 8'h00, 28'h123);
    err_addr = g_a2f; err_ops = 3'b001;
    run_walk(32'h5555_5000, 0, 0, 0);
    build(32'h6666_6000, 1, 8'h00, 28'h123);
    err_addr = g_a1; err_ops = 3'b010;
    run_walk(32'h6666_6000, 0, 0, 0);
    build(32'h6666_6000, 2, 8'h00, 28'h123);
    err_addr = g_a2f; err_ops = 3'b100;
    run_walk(32'h6666_6000, 1, 1, 0);
    err_addr = '1; err_ops = 0;
    // R9 miss while busy
    build(32'h9999_9000, 2, 8'h00, 28'h456);
    run_walk(32'h9999_9000, 1, 0, 1);

    for (int i = 0; i < 80; i++) begin
      logic [31:0] va;
      int kind, nf, pick;
      ptpr_i = 27'($urandom);
      va = $urandom;
      kind = $urandom % 4;
      nf = $urandom % 3;
      build(va, kind, 8'($urandom), 28'($urandom));
      err_addr = '1; err_ops = 0;
      pick = $urandom % 8;
      if (pick == 0) begin err_addr = g_a1; err_ops = 3'b001; end
      else if (pick == 1) begin err_addr = g_a2f; err_ops = 3'b001; end
      else if (pick == 2) begin err_addr = g_a2f | 40'h4; err_ops = 3'b001; end
      else if (pick == 3) begin err_addr = (kind == 1) ? g_a1 : g_a2f; err_ops = 3'b010; end
      else if (pick == 4) begin err_addr = (kind == 1) ? g_a1 : g_a2f; err_ops = 3'b100; end
      run_walk(va, 1'($urandom), nf, (i % 9) == 0);
    end
    summary();
  end
endmodule